// File: doc/BRIEF.md
# Nonvolatile memory command controller

This block holds a 16-bit control word for an on-chip nonvolatile array and runs the sequence for one self-timed program or erase operation at a time. Software writes the control word over a simple register port and reads it back at any time. To start an operation, software writes the word with the start bit and the enable bit both set. The block then decodes the erase/program select and the 6-bit operation field into a command class and a row count. It captures the row address from the table-pointer input and gives the memory back end a one-cycle start pulse. It holds the start bit at 1 until the back end reports done, and then clears the bit in hardware.

Improper start attempts raise an error flag and never reach the back end. An improper attempt is a start while the enable bit is clear, or a start while an operation is already running. An operation field with no defined meaning is accepted without a back-end pulse: the start bit reads 1 for one cycle and then falls. While an operation is active, the select bit and the operation field are frozen, so the command presented to the back end cannot change under it.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset every bit of `reg_rdata` is 0, and `be_start` is 0.
- R2: Bits 11 to 7 of `reg_rdata` always read 0, whatever is written to them.
- R3: A write with bit 15 = 1 and bit 14 = 1, made while the start bit reads 0 and carrying a defined code, makes `be_start` high for exactly the one cycle after the write edge. The start bit (bit 15) reads 1 from the cycle after the write edge until completion. Command class codes on `be_op`: 0 none, 1 boot erase, 2 full erase, 3 row erase, 4 configuration erase, 5 data-EEPROM erase, 6 general-block erase, 7 row program.
- R4: The start bit reads 0 from the cycle after the clock edge that samples `be_done` high during an active command, and that completion clears the error flag (bit 13).
- R5: A start write with bit 14 = 0 issues no `be_start`, leaves the start bit at 0 and sets bit 13.
- R6: A start write while the start bit reads 1 issues no new `be_start`, sets bit 13 and leaves the active command running.
- R7: An accepted start with an undefined code issues no `be_start`; the start bit reads 1 for one cycle and then 0.
- R8: With bit 6 = 1, the operation field (bits 5:0) decodes as follows. 1010xx gives class 1 and 1001xx gives class 2. Row erases are class 3: 011000 erases 1 row, 011001 erases 2 rows and 011010 erases 4 rows. 0101xx gives class 4, 0100xx gives class 5 and 0011xx gives class 6. Any other value is undefined. `be_rows` carries the row count for class 3 and 0 for every other class.
- R9: With bit 6 = 0, 0001xx gives class 7 with `be_rows` = 1, and every other value is undefined.
- R10: `be_row` takes `tblptr_row` at the accepting write edge and stays unchanged while the start bit reads 1.
- R11: While the start bit reads 1, writes to bit 6 and bits 5:0 are ignored.
- R12: Writing 0 to bit 15 never clears the start bit.
- R13: Bits 14, 13 and 12 are written directly by every register write (bit 13 can be cleared this way) and read back in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read value |
| tblptr_row | input | ROW_W | Row address from the table pointer |
| be_start | output | 1 | One-cycle command start to the back end |
| be_op | output | 3 | Command class code |
| be_rows | output | 3 | Row count for row erases and programs |
| be_row | output | ROW_W | Captured row address |
| be_done | input | 1 | Back end reports completion |

## Verification
The bench walks all 128 combinations of the select bit and the operation field. It compares every back-end pulse against a reference decode, so a design that swaps row counts, ignores the don't-care low bits or pulses on an undefined code shows up as a wrong or unexpected pulse. It attempts a second start during an active operation, changes the table pointer at the same time and writes a cleared start bit. A design that let the second start through would emit an extra pulse; one that let the operation field change, tracked the live pointer or let software clear the start bit would be caught by the read-back or the row compare. The error flag is checked to rise on a disabled start and to drop on normal completion.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int CW_W      = 16;
    localparam int OPF_W     = 6;
    localparam int ROWS_W    = 3;
    localparam int B_START   = 15;
    localparam int B_WEN     = 14;
    localparam int B_ERR     = 13;
    localparam int B_EEPO    = 12;
    localparam int B_ERSEL   = 6;

    typedef enum logic [2:0] {
        OPC_NONE    = 3'd0,
        OPC_ER_BOOT = 3'd1,
        OPC_ER_ALL  = 3'd2,
        OPC_ER_ROWS = 3'd3,
        OPC_ER_CFG  = 3'd4,
        OPC_ER_EE   = 3'd5,
        OPC_ER_GEN  = 3'd6,
        OPC_PR_ROW  = 3'd7
    } opc_t;

    typedef struct packed {
        opc_t              op;
        logic [ROWS_W-1:0] rows;
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_NOP   = 2'd3
    } sq_t;

endpackage

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
    import nvm_pkg::*;
(
    input  logic             erase_sel,
    input  logic [OPF_W-1:0] opfield,
    output cmd_t             cmd
);

    logic [3:0] grp;
    logic [1:0] sub;

    assign grp = opfield[OPF_W-1:2];
    assign sub = opfield[1:0];

    always_comb begin
        cmd.op   = OPC_NONE;
        cmd.rows = '0;
        if (erase_sel) begin
            unique case (grp)
                4'b1010: cmd.op = OPC_ER_BOOT;
                4'b1001: cmd.op = OPC_ER_ALL;
                4'b0101: cmd.op = OPC_ER_CFG;
                4'b0100: cmd.op = OPC_ER_EE;
                4'b0011: cmd.op = OPC_ER_GEN;
                4'b0110: begin
                    if (sub != 2'b11) begin
                        cmd.op   = OPC_ER_ROWS;
                        cmd.rows = ROWS_W'(1) << sub;
                    end
                end
                default: cmd.op = OPC_NONE;
            endcase
        end else if (grp == 4'b0001) begin
            cmd.op   = OPC_PR_ROW;
            cmd.rows = ROWS_W'(1);
        end
    end

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic is_nop,
    input  logic be_done,
    output logic busy,
    output logic issue,
    output logic complete
);

    typedef struct packed {
        sq_t st;
    } seq_s;

    seq_s d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            SQ_IDLE:  if (accept) d.st = is_nop ? SQ_NOP : SQ_ISSUE;
            SQ_ISSUE: d.st = SQ_WAIT;
            SQ_WAIT:  if (be_done) d.st = SQ_IDLE;
            SQ_NOP:   d.st = SQ_IDLE;
            default:  d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_IDLE};
        else        q <= d;
    end

    assign busy     = (q.st != SQ_IDLE);
    assign issue    = (q.st == SQ_ISSUE);
    assign complete = (q.st == SQ_WAIT) && be_done;

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [ROW_W-1:0] tblptr_row,
    output logic             be_start,
    output logic [2:0]       be_op,
    output logic [2:0]       be_rows,
    output logic [ROW_W-1:0] be_row,
    input  logic             be_done
);

    typedef struct packed {
        logic             wen;
        logic             err;
        logic             eepo;
        logic             ersel;
        logic [OPF_W-1:0] opf;
        cmd_t             cmd;
        logic [ROW_W-1:0] row;
    } regs_s;

    regs_s d, q;

    logic busy, issue, complete;
    logic wr_start, accept, reject;
    cmd_t dec_cmd;

    nvm_op_decode u_dec (
        .erase_sel (reg_wdata[B_ERSEL]),
        .opfield   (reg_wdata[OPF_W-1:0]),
        .cmd       (dec_cmd)
    );

    assign wr_start = reg_we && reg_wdata[B_START];
    assign accept   = wr_start && !busy && reg_wdata[B_WEN];
    assign reject   = wr_start && (busy || !reg_wdata[B_WEN]);

    nvm_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .is_nop   (dec_cmd.op == OPC_NONE),
        .be_done  (be_done),
        .busy     (busy),
        .issue    (issue),
        .complete (complete)
    );

    always_comb begin
        d = q;
        if (reg_we) begin
            d.wen  = reg_wdata[B_WEN];
            d.err  = reg_wdata[B_ERR];
            d.eepo = reg_wdata[B_EEPO];
            if (!busy) begin
                d.ersel = reg_wdata[B_ERSEL];
                d.opf   = reg_wdata[OPF_W-1:0];
            end
        end
        if (accept) begin
            d.cmd = dec_cmd;
            d.row = tblptr_row;
        end
        if (complete) d.err = 1'b0;
        if (reject)   d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[B_START]     = busy;
        reg_rdata[B_WEN]       = q.wen;
        reg_rdata[B_ERR]       = q.err;
        reg_rdata[B_EEPO]      = q.eepo;
        reg_rdata[B_ERSEL]     = q.ersel;
        reg_rdata[OPF_W-1:0]   = q.opf;
    end

    assign be_start = issue;
    assign be_op    = q.cmd.op;
    assign be_rows  = q.cmd.rows;
    assign be_row   = q.row;

endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk #(
    parameter int ROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [15:0]      reg_wdata,
    input logic [15:0]      reg_rdata,
    input logic             be_start,
    input logic [ROW_W-1:0] be_row,
    input logic             be_done
);

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[11:7] == 5'd0);                                             // R2

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> !be_start);                                              // R3

    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> reg_rdata[15]);                                          // R3

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (be_done && reg_rdata[15] && !be_start) |=> !reg_rdata[15]);          // R4

    AST_REJECT_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[15] && !reg_wdata[14] && !reg_rdata[15])
        |=> (!be_start && !reg_rdata[15] && reg_rdata[13]));                  // R5

    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15] && $past(reg_rdata[15])) |-> $stable(be_row));         // R10

    AST_OP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15] && $past(reg_rdata[15])) |-> $stable(reg_rdata[6:0])); // R11

    AST_NO_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (be_start && reg_we && !reg_wdata[15]) |=> reg_rdata[15]);            // R12

endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .be_start  (be_start),
    .be_row    (be_row),
    .be_done   (be_done)
);

// File: tb/sim_nvm_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_cmd_ctrl;

    localparam int ROW_W = 16;
    localparam int LAT   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic [ROW_W-1:0] tblptr_row = '0;
    logic             be_start;
    logic [2:0]       be_op;
    logic [2:0]       be_rows;
    logic [ROW_W-1:0] be_row;
    logic             be_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [21:0] expq [$];

    always #2.5 clk = ~clk;

    nvm_cmd_ctrl #(.ROW_W(ROW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tblptr_row(tblptr_row), .be_start(be_start),
        .be_op(be_op), .be_rows(be_rows), .be_row(be_row), .be_done(be_done)
    );

    // counter-based back-end model
    logic [3:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            be_done <= 1'b0;
        end else begin
            be_done <= 1'b0;
            if (be_start) cnt <= 4'(LAT);
            else if (cnt != 0) begin
                cnt <= cnt - 1'b1;
                if (cnt == 1) be_done <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference decode: {class, rows}
    function automatic logic [5:0] ref_cmd(input logic er, input logic [5:0] op);
        logic [5:0] r = '0;
        if (er) begin
            case (op[5:2])
                4'b1010: r = {3'd1, 3'd0};
                4'b1001: r = {3'd2, 3'd0};
                4'b0101: r = {3'd4, 3'd0};
                4'b0100: r = {3'd5, 3'd0};
                4'b0011: r = {3'd6, 3'd0};
                4'b0110: case (op[1:0])
                    2'b00: r = {3'd3, 3'd1};
                    2'b01: r = {3'd3, 3'd2};
                    2'b10: r = {3'd3, 3'd4};
                    default: r = '0;
                endcase
                default: r = '0;
            endcase
        end else if (op[5:2] == 4'b0001) r = {3'd7, 3'd1};
        return r;
    endfunction

    // monitor: every pulse must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && be_start) begin
            if (expq.size() == 0)
                chk(1'b0, "R6/R7 unexpected start pulse", 32'(be_op), 32'd0);
            else begin
                logic [21:0] e;
                e = expq.pop_front();
                chk({be_op, be_rows} == e[21:16], "R8/R9 command decode",
                    32'({be_op, be_rows}), 32'(e[21:16]));
                chk(be_row == e[15:0], "R10 captured row", 32'(be_row), 32'(e[15:0]));
            end
        end
    end

    task automatic reg_write(input logic [15:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40 && reg_rdata[15]; k++) @(negedge clk);
        chk(reg_rdata[15] == 1'b0, "R4 start bit cleared", 32'(reg_rdata[15]), 32'd0);
    endtask

    task automatic do_cmd(input logic er, input logic [5:0] op, input logic [15:0] row);
        logic [5:0] e;
        e = ref_cmd(er, op);
        tblptr_row = row;
        if (e[5:3] != 3'd0) expq.push_back({e, row});
        reg_write({1'b1, 1'b1, 1'b0, 1'b0, 5'b0, er, op});
        chk(reg_rdata[15] == 1'b1, "R3 start bit set", 32'(reg_rdata[15]), 32'd1);
        if (e[5:3] == 3'd0) begin
            chk(be_start == 1'b0, "R7 no pulse on undefined code", 32'(be_start), 32'd0);
            @(negedge clk);
            chk(reg_rdata[15] == 1'b0, "R7 start clears after one cycle",
                32'(reg_rdata[15]), 32'd0);
        end else begin
            chk(be_start == 1'b1, "R3 pulse after write", 32'(be_start), 32'd1);
            wait_idle();
            chk(reg_rdata[13] == 1'b0, "R4 error flag after completion",
                32'(reg_rdata[13]), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(reg_rdata == 16'h0000, "R1 reset value", 32'(reg_rdata), 32'h0);
        chk(be_start == 1'b0, "R1 no pulse in reset", 32'(be_start), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 16'h0000, "R1 value after reset", 32'(reg_rdata), 32'h0);

        // R2 / R13: plain field writes
        reg_write(16'h7FFF);
        chk(reg_rdata == 16'h707F, "R2 R13 read back", 32'(reg_rdata), 32'h707F);
        reg_write(16'h0000);
        chk(reg_rdata == 16'h0000, "R13 clear by write", 32'(reg_rdata), 32'h0);

        // R5: start without enable
        reg_write(16'h8058);
        chk(reg_rdata == 16'h2058, "R5 rejected start", 32'(reg_rdata), 32'h2058);
        chk(be_start == 1'b0, "R5 no pulse", 32'(be_start), 32'd0);
        @(negedge clk);
        chk(be_start == 1'b0, "R5 no pulse later", 32'(be_start), 32'd0);
        reg_write(16'h0000);

        // R8 / R9 / R3 / R7: full sweep of select and operation field
        for (int i = 0; i < 128; i++)
            do_cmd(i[6], i[5:0], 16'h1000 + 16'(i));

        // R6 / R10 / R11 / R12: activity while busy
        do begin
            logic [5:0] e;
            e = ref_cmd(1'b1, 6'b011000);
            tblptr_row = 16'h0ABC;
            expq.push_back({e, 16'h0ABC});
            reg_write(16'hC058);
            chk(be_start == 1'b1, "R3 pulse for row erase", 32'(be_start), 32'd1);
            tblptr_row = 16'h5555;
            reg_write(16'hC05A);
            chk(reg_rdata[15] == 1'b1, "R6 active command continues",
                32'(reg_rdata[15]), 32'd1);
            chk(reg_rdata[13] == 1'b1, "R6 error on busy start",
                32'(reg_rdata[13]), 32'd1);
            chk(reg_rdata[6:0] == 7'h58, "R11 op field frozen",
                32'(reg_rdata[6:0]), 32'h58);
            chk(be_row == 16'h0ABC, "R10 row held", 32'(be_row), 32'h0ABC);
            reg_write(16'h6058);
            chk(reg_rdata[15] == 1'b1, "R12 software cannot clear start",
                32'(reg_rdata[15]), 32'd1);
            wait_idle();
            chk(reg_rdata[13] == 1'b0, "R4 error cleared by completion",
                32'(reg_rdata[13]), 32'd0);
        end while (0);

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R3 all expected pulses seen", 32'(expq.size()), 32'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule